// File: doc/BRIEF.md
# Multicore Interrupt Distributor

This block sits between the interrupt sources of a multicore cluster and the cores themselves. External interrupt lines come in as levels. Software can gate each line with an enable mask, or force a line active with an assert mask. A per-line routing word then steers the line to any subset of cores. The block also holds sixteen inter-processor interrupt (IPI) cause bits per core. These bits are folded into three IPI interrupt levels through a programmable partition. Each core receives one interrupt vector: the IPI levels sit in bits 0 to 2, and external line k sits in bit k+2. A run-stall output per core lets software hold cores in reset-like idle.

Software reaches all state through one register port. A request carries an address, write data and the index of the core making the request. The requester index selects the per-core control bit, and it is also reported in the configuration ID word. Read data is registered and appears in the cycle after the request. Every core output is registered as well.

Top module: `irq_distributor`

## Requirements
- R1: For each core, vector bits from 2 upward equal ((line_in AND enable mask) OR assert mask) AND the lines routed to that core, with line k placed at bit k+2.
- R2: Routing word k lives at offset k (k below NUM_LINES), and bit c of the word routes line k to core c. Reads return the word zero-extended to 32 bits. Offsets from NUM_LINES up to 0xFF are unmapped.
- R3: Vector bits 0 to 2 carry the IPI levels. Cause bit 0 raises the level named by partition[1:0]. The OR of cause bits 3:1 raises the level named by partition[3:2]. The OR of bits 7:4 raises the level named by partition[5:4]. The OR of bits 15:8 raises the level named by partition[7:6]. A level value of 3 is dropped. Bit 2 is ORed with the line 0 path.
- R4: A write to 0x140+n (n from 0 to 15) sets cause bit n in every core c whose data bit c is 1.
- R5: A write to 0x100+c clears the cause bits of core c that are written as 1 and keeps the rest. A read of the same offset returns the 16 cause bits.
- R6: Enable mask: 0x180 clears the bits written as 1, 0x184 sets them, and reads at 0x180 return the mask. Assert mask: 0x188 clears, 0x18C sets, and reads at 0x188 return the mask. Reads at 0x184 and 0x18C return zero.
- R7: The partition register at 0x190 holds data bits 7:0 and reads back zero-extended.
- R8: A read at 0x1A0 returns ((NUM_CORES-1) << 18) | requesting core index. Writes to this offset change nothing.
- R9: Bit c of the run-stall register at 0x200 drives stall[c]. The register reads back.
- R10: Offset 0x220 holds a single bit (data bit 0) per core, indexed by the requesting core. Reads return that core's bit.
- R11: After reset: the enable mask is all ones, every routing word is 1, the assert mask, partition, causes and control bits are 0, stall is all ones except core 0, and all vectors are 0.
- R12: Reads at unmapped offsets, including the IPI-set range, return zero. Writes there change no state.
- R13: Read data appears in the cycle after the request. A write, or a change on line_in, shows on the core vectors at the clock edge after the one that captured it. stall follows a write at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Register offset |
| req_core | input | CORE_IDX_W | Index of the requesting core |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after a read |
| line_in | input | NUM_LINES | External interrupt line levels |
| core_irq | output | NUM_CORES*(NUM_LINES+2) | Per-core interrupt vectors; core c at [c*(NUM_LINES+2) +: NUM_LINES+2] |
| stall | output | NUM_CORES | Per-core run-stall |

## Verification
The bench builds the block with four cores and the full 32 lines. This puts the routing offsets directly against the unmapped gap at 0x20. It also lets the 32-bit enable reset value reach all ones, and it gives a configuration ID of 3 << 18 plus the requester. With four cores, IPI-set data can select any core subset while the higher data bits have no target. The two-bit requester index covers every control slot, and stall can take every combination. Random accesses against a bench model are mixed with directed partition cases. These include a level of 3 and the overlap of the IPI and line 0 paths at bit 2.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 32;
    localparam int IPI_BITS   = 16;
    localparam int IPI_LEVELS = 3;
    localparam int PART_W     = 8;
    localparam int CFG_SHIFT  = 18;

    localparam int OFF_CAUSE  = 'h100;
    localparam int OFF_IPISET = 'h140;
    localparam int OFF_EN_CLR = 'h180;
    localparam int OFF_EN_SET = 'h184;
    localparam int OFF_AS_CLR = 'h188;
    localparam int OFF_AS_SET = 'h18C;
    localparam int OFF_PART   = 'h190;
    localparam int OFF_CFGID  = 'h1A0;
    localparam int OFF_STALL  = 'h200;
    localparam int OFF_CTRL   = 'h220;

    typedef enum logic [3:0] {
        K_NONE, K_ROUTE, K_CAUSE, K_IPISET, K_EN_CLR, K_EN_SET,
        K_AS_CLR, K_AS_SET, K_PART, K_CFGID, K_STALL, K_CTRL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [ADDR_W-1:0]  idx;
    } decode_t;

    function automatic decode_t decode_addr(logic [ADDR_W-1:0] a, int nl, int nc);
        decode_t d;
        int ai;
        ai     = int'(a);
        d.kind = K_NONE;
        d.idx  = '0;
        if (ai < nl) begin
            d.kind = K_ROUTE;
            d.idx  = a;
        end else if (ai >= OFF_CAUSE && ai < OFF_CAUSE + nc) begin
            d.kind = K_CAUSE;
            d.idx  = ADDR_W'(ai - OFF_CAUSE);
        end else if (ai >= OFF_IPISET && ai < OFF_IPISET + IPI_BITS) begin
            d.kind = K_IPISET;
            d.idx  = ADDR_W'(ai - OFF_IPISET);
        end else begin
            case (ai)
                OFF_EN_CLR: d.kind = K_EN_CLR;
                OFF_EN_SET: d.kind = K_EN_SET;
                OFF_AS_CLR: d.kind = K_AS_CLR;
                OFF_AS_SET: d.kind = K_AS_SET;
                OFF_PART:   d.kind = K_PART;
                OFF_CFGID:  d.kind = K_CFGID;
                OFF_STALL:  d.kind = K_STALL;
                OFF_CTRL:   d.kind = K_CTRL;
                default:    d.kind = K_NONE;
            endcase
        end
        return d;
    endfunction

    // Fold the cause groups onto the three IPI levels; level 3 falls off.
    function automatic logic [IPI_LEVELS-1:0] ipi_levels(logic [IPI_BITS-1:0] cause,
                                                         logic [PART_W-1:0]   part);
        logic [3:0] lvl;
        lvl = '0;
        lvl[part[1:0]] = lvl[part[1:0]] | cause[0];
        lvl[part[3:2]] = lvl[part[3:2]] | (|cause[3:1]);
        lvl[part[5:4]] = lvl[part[5:4]] | (|cause[7:4]);
        lvl[part[7:6]] = lvl[part[7:6]] | (|cause[15:8]);
        return lvl[IPI_LEVELS-1:0];
    endfunction

endpackage

// File: rtl/irqd_regfile.sv
module irqd_regfile
    import irqd_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 32,
    localparam int CIW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int LIW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  req_valid,
    input  logic                                  req_write,
    input  logic [ADDR_W-1:0]                     req_addr,
    input  logic [CIW-1:0]                        req_core,
    input  logic [DATA_W-1:0]                     req_wdata,
    output logic [DATA_W-1:0]                     rdata,
    output logic [NUM_LINES-1:0][NUM_CORES-1:0]   route,
    output logic [NUM_LINES-1:0]                  en_mask,
    output logic [NUM_LINES-1:0]                  asrt_mask,
    output logic [PART_W-1:0]                     part,
    output logic [NUM_CORES-1:0][IPI_BITS-1:0]    cause,
    output logic [NUM_CORES-1:0]                  stall_q
);

    logic [NUM_CORES-1:0] ctrl_q;
    decode_t              dec;
    logic                 wr_en;
    logic                 rd_en;
    logic                 core_ok;
    logic [DATA_W-1:0]    rd_val;

    assign dec     = decode_addr(req_addr, NUM_LINES, NUM_CORES);
    assign wr_en   = req_valid && req_write;
    assign rd_en   = req_valid && !req_write;
    assign core_ok = int'(req_core) < NUM_CORES;

    always_comb begin
        rd_val = '0;
        case (dec.kind)
            K_ROUTE:  rd_val = DATA_W'(route[dec.idx[LIW-1:0]]);
            K_CAUSE:  rd_val = DATA_W'(cause[dec.idx[CIW-1:0]]);
            K_EN_CLR: rd_val = DATA_W'(en_mask);
            K_AS_CLR: rd_val = DATA_W'(asrt_mask);
            K_PART:   rd_val = DATA_W'(part);
            K_CFGID:  rd_val = (DATA_W'(NUM_CORES - 1) << CFG_SHIFT) | DATA_W'(req_core);
            K_STALL:  rd_val = DATA_W'(stall_q);
            K_CTRL:   rd_val = core_ok ? DATA_W'(ctrl_q[req_core]) : '0;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_LINES; k++) begin
                route[k] <= NUM_CORES'(1);
            end
            en_mask   <= '1;
            asrt_mask <= '0;
            part      <= '0;
            cause     <= '0;
            stall_q   <= ~NUM_CORES'(1);
            ctrl_q    <= '0;
            rdata     <= '0;
        end else begin
            rdata <= rd_en ? rd_val : '0;
            if (wr_en) begin
                case (dec.kind)
                    K_ROUTE:  route[dec.idx[LIW-1:0]] <= req_wdata[NUM_CORES-1:0];
                    K_CAUSE:  cause[dec.idx[CIW-1:0]] <= cause[dec.idx[CIW-1:0]]
                                                         & ~req_wdata[IPI_BITS-1:0];
                    K_IPISET: begin
                        for (int c = 0; c < NUM_CORES; c++) begin
                            if (req_wdata[c]) begin
                                cause[c][dec.idx[3:0]] <= 1'b1;
                            end
                        end
                    end
                    K_EN_CLR: en_mask   <= en_mask & ~req_wdata[NUM_LINES-1:0];
                    K_EN_SET: en_mask   <= en_mask | req_wdata[NUM_LINES-1:0];
                    K_AS_CLR: asrt_mask <= asrt_mask & ~req_wdata[NUM_LINES-1:0];
                    K_AS_SET: asrt_mask <= asrt_mask | req_wdata[NUM_LINES-1:0];
                    K_PART:   part      <= req_wdata[PART_W-1:0];
                    K_STALL:  stall_q   <= req_wdata[NUM_CORES-1:0];
                    K_CTRL: begin
                        if (core_ok) begin
                            ctrl_q[req_core] <= req_wdata[0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/irqd_core_port.sv
module irqd_core_port
    import irqd_pkg::*;
#(
    parameter int NUM_LINES = 32,
    localparam int VEC_W = NUM_LINES + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] line_eff,
    input  logic [NUM_LINES-1:0] route_col,
    input  logic [IPI_BITS-1:0]  cause,
    input  logic [PART_W-1:0]    part,
    output logic [VEC_W-1:0]     vec
);

    logic [VEC_W-1:0] vec_d;

    always_comb begin
        vec_d = {line_eff & route_col, 2'b00};
        vec_d = vec_d | VEC_W'(ipi_levels(cause, part));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec <= '0;
        end else begin
            vec <= vec_d;
        end
    end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 32,
    localparam int CORE_IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int VEC_W      = NUM_LINES + 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [9:0]                   req_addr,
    input  logic [CORE_IDX_W-1:0]        req_core,
    input  logic [31:0]                  req_wdata,
    output logic [31:0]                  rdata,
    input  logic [NUM_LINES-1:0]         line_in,
    output logic [NUM_CORES*VEC_W-1:0]   core_irq,
    output logic [NUM_CORES-1:0]         stall
);

    logic [NUM_LINES-1:0][NUM_CORES-1:0] route;
    logic [NUM_LINES-1:0]                en_mask;
    logic [NUM_LINES-1:0]                asrt_mask;
    logic [PART_W-1:0]                   part;
    logic [NUM_CORES-1:0][IPI_BITS-1:0]  cause;
    logic [NUM_LINES-1:0]                line_eff;

    irqd_regfile #(
        .NUM_CORES (NUM_CORES),
        .NUM_LINES (NUM_LINES)
    ) u_regfile (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_core  (req_core),
        .req_wdata (req_wdata),
        .rdata     (rdata),
        .route     (route),
        .en_mask   (en_mask),
        .asrt_mask (asrt_mask),
        .part      (part),
        .cause     (cause),
        .stall_q   (stall)
    );

    assign line_eff = (line_in & en_mask) | asrt_mask;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [NUM_LINES-1:0] col;
        for (genvar k = 0; k < NUM_LINES; k++) begin : g_col
            assign col[k] = route[k][c];
        end
        irqd_core_port #(
            .NUM_LINES (NUM_LINES)
        ) u_port (
            .clk       (clk),
            .rst       (rst),
            .line_eff  (line_eff),
            .route_col (col),
            .cause     (cause[c]),
            .part      (part),
            .vec       (core_irq[c*VEC_W +: VEC_W])
        );
    end

endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
    import irqd_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 32,
    localparam int CIW   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int VEC_W = NUM_LINES + 2
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 req_valid,
    input logic                                 req_write,
    input logic [9:0]                           req_addr,
    input logic [CIW-1:0]                       req_core,
    input logic [31:0]                          req_wdata,
    input logic [31:0]                          rdata,
    input logic [NUM_LINES-1:0]                 line_in,
    input logic [NUM_CORES*VEC_W-1:0]           core_irq,
    input logic [NUM_CORES-1:0]                 stall,
    input logic [NUM_LINES-1:0]                 en_mask,
    input logic [NUM_LINES-1:0]                 asrt_mask,
    input logic [NUM_CORES-1:0][IPI_BITS-1:0]   cause
);

    logic                 past_ok;
    logic [NUM_LINES-1:0] eff_q;
    logic [NUM_CORES-1:0] idle_q;
    logic                 unmapped;
    int                   ai;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
            eff_q   <= '0;
            idle_q  <= '1;
        end else begin
            past_ok <= 1'b1;
            eff_q   <= (line_in & en_mask) | asrt_mask;
            for (int c = 0; c < NUM_CORES; c++) begin
                idle_q[c] <= (cause[c] == '0);
            end
        end
    end

    always_comb begin
        ai = int'(req_addr);
        unmapped = !((ai < NUM_LINES) ||
                     (ai >= OFF_CAUSE && ai < OFF_CAUSE + NUM_CORES) ||
                     ai == OFF_EN_CLR || ai == OFF_AS_CLR || ai == OFF_PART ||
                     ai == OFF_CFGID || ai == OFF_STALL || ai == OFF_CTRL);
    end

    AST_STALL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && int'(req_addr) == OFF_STALL)
        |=> (stall == $past(req_wdata[NUM_CORES-1:0])));  // R9

    AST_CFGID_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && int'(req_addr) == OFF_CFGID)
        |=> (rdata == ((32'(NUM_CORES - 1) << CFG_SHIFT) | 32'($past(req_core)))));  // R8

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && unmapped) |=> (rdata == '0));  // R12

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        AST_NO_STRAY_LINE: assert property (@(posedge clk) disable iff (rst)
            past_ok |-> ((core_irq[c*VEC_W+3 +: NUM_LINES-1] & ~eff_q[NUM_LINES-1:1]) == '0));  // R1
        AST_IPI_IDLE: assert property (@(posedge clk) disable iff (rst)
            (past_ok && idle_q[c]) |-> (core_irq[c*VEC_W +: 2] == 2'b00));  // R3
    end

endmodule

bind irq_distributor irqd_checker #(
    .NUM_CORES (NUM_CORES),
    .NUM_LINES (NUM_LINES)
) u_irqd_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_core  (req_core),
    .req_wdata (req_wdata),
    .rdata     (rdata),
    .line_in   (line_in),
    .core_irq  (core_irq),
    .stall     (stall),
    .en_mask   (en_mask),
    .asrt_mask (asrt_mask),
    .cause     (cause)
);

// File: tb/irq_distributor_bench.sv
module irq_distributor_bench;

    localparam int NC = 4;
    localparam int NL = 32;
    localparam int VW = NL + 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_write;
    logic [9:0]        req_addr;
    logic [1:0]        req_core;
    logic [31:0]       req_wdata;
    logic [31:0]       rdata;
    logic [NL-1:0]     line_in;
    logic [NC*VW-1:0]  core_irq;
    logic [NC-1:0]     stall;

    int checks = 0;
    int errors = 0;

    logic [NL-1:0][NC-1:0] m_route;
    logic [NL-1:0]         m_en, m_as, m_lines;
    logic [7:0]            m_part;
    logic [NC-1:0][15:0]   m_cause;
    logic [NC-1:0]         m_stall, m_ctrl;

    always #10 clk = ~clk;

    irq_distributor #(.NUM_CORES(NC), .NUM_LINES(NL)) u_irq_distributor (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_core(req_core), .req_wdata(req_wdata),
        .rdata(rdata), .line_in(line_in), .core_irq(core_irq), .stall(stall)
    );

    function automatic logic [2:0] ipi_exp(logic [15:0] c, logic [7:0] p);
        logic [3:0] l;
        l = '0;
        if (c[0])      l[p[1:0]] = 1'b1;
        if (|c[3:1])   l[p[3:2]] = 1'b1;
        if (|c[7:4])   l[p[5:4]] = 1'b1;
        if (|c[15:8])  l[p[7:6]] = 1'b1;
        return l[2:0];
    endfunction

    function automatic logic [VW-1:0] exp_vec(int c);
        logic [NL-1:0] col;
        logic [VW-1:0] v;
        for (int k = 0; k < NL; k++) col[k] = m_route[k][c];
        v = {((m_lines & m_en) | m_as) & col, 2'b00};
        v[2:0] = v[2:0] | ipi_exp(m_cause[c], m_part);
        return v;
    endfunction

    function automatic logic [31:0] exp_read(int a, int core);
        if (a < NL) return 32'(m_route[a]);
        if (a >= 'h100 && a < 'h100 + NC) return 32'(m_cause[a - 'h100]);
        case (a)
            'h180: return m_en;
            'h188: return m_as;
            'h190: return 32'(m_part);
            'h1A0: return (32'(NC - 1) << 18) | 32'(core);
            'h200: return 32'(m_stall);
            'h220: return 32'(m_ctrl[core]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(int a, int core, logic [31:0] d);
        if (a < NL) m_route[a] = d[NC-1:0];
        else if (a >= 'h100 && a < 'h100 + NC) m_cause[a - 'h100] &= ~d[15:0];
        else if (a >= 'h140 && a < 'h150) begin
            for (int c = 0; c < NC; c++) if (d[c]) m_cause[c][a - 'h140] = 1'b1;
        end else begin
            case (a)
                'h180: m_en &= ~d;
                'h184: m_en |= d;
                'h188: m_as &= ~d;
                'h18C: m_as |= d;
                'h190: m_part = d[7:0];
                'h200: m_stall = d[NC-1:0];
                'h220: m_ctrl[core] = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NL; k++) m_route[k] = NC'(1);
        m_en = '1; m_as = '0; m_part = '0; m_cause = '0;
        m_stall = ~NC'(1); m_ctrl = '0; m_lines = '0;
    endtask

    task automatic check(logic ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < NC; c++) begin
            logic [VW-1:0] e;
            e = exp_vec(c);
            check(core_irq[c*VW +: VW] === e, req, 64'(core_irq[c*VW +: VW]), 64'(e));
        end
        check(stall === m_stall, "R9 stall", 64'(stall), 64'(m_stall));
    endtask

    task automatic access(logic wr, int a, int core, logic [31:0] d, string req);
        logic [31:0] er;
        er = exp_read(a, core);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 10'(a);
        req_core = 2'(core); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (!wr) check(rdata === er, {req, " R13 read"}, 64'(rdata), 64'(er));
        else model_write(a, core, d);
        @(negedge clk);
        check_all({req, " R1 R3 vectors"});
    endtask

    task automatic set_lines(logic [NL-1:0] v);
        @(negedge clk);
        line_in = v; m_lines = v;
        @(negedge clk);
        check_all("R1 R13 line change");
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int addrs [14] = '{0, 5, 31, 'h20, 'h100, 'h103, 'h145, 'h180,
                           'h184, 'h188, 'h190, 'h1A0, 'h200, 'h220};
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; req_valid = 0; req_write = 0; req_addr = 0;
        req_core = 0; req_wdata = 0; line_in = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R11 reset vectors");
        check(stall === 4'b1110, "R11 reset stall", 64'(stall), 64'hE);
        access(0, 'h180, 0, 0, "R11 reset enable");
        access(0, 5, 0, 0, "R11 reset route");
        access(0, 'h190, 1, 0, "R11 reset partition");

        // R1 lines to core 0 only
        set_lines(32'hA5A5_0F0E);
        // R2 route line 3 to cores 1 and 2, line 8 to all
        access(1, 3, 0, 32'h6, "R2 route write");
        access(1, 8, 2, 32'hF, "R2 route write all");
        access(0, 3, 3, 0, "R2 route read");
        // R2 R12 offset just past the routing words
        access(1, 'h20, 0, 32'hF, "R12 unmapped write");
        access(0, 'h20, 0, 0, "R12 unmapped read");
        // R6 enable and assert masks
        access(1, 'h180, 0, 32'h8, "R6 enable clear");
        access(1, 'h18C, 0, 32'h10, "R6 assert set");
        access(0, 'h184, 0, 0, "R6 set address reads zero");
        access(0, 'h188, 1, 0, "R6 assert read");
        access(1, 'h184, 0, 32'h8, "R6 enable set");
        // R7 R3 partition with one group per level and a dropped group
        access(1, 'h190, 0, 32'h1E4, "R7 partition write");
        access(0, 'h190, 0, 0, "R7 partition read");
        access(1, 'h140, 0, 32'h3, "R4 ipi set bit 0");
        access(1, 'h149, 0, 32'h4, "R4 R3 level 3 dropped");
        access(1, 'h145, 0, 32'h8, "R4 R3 group to bit 2");
        access(1, 'h142, 0, 32'h2, "R4 ipi set bit 2");
        access(0, 'h101, 0, 0, "R5 cause read");
        access(1, 'h101, 0, 32'h1, "R5 cause clear");
        access(0, 'h101, 3, 0, "R5 cause read after clear");
        // R3 bit 2 overlap with line 0
        set_lines(32'h1);
        access(1, 'h190, 0, 32'h0, "R3 all groups to level 0");
        // R8 configuration ID per requester
        for (int c = 0; c < NC; c++) access(0, 'h1A0, c, 0, "R8 config id");
        access(1, 'h1A0, 0, 32'hFFFF, "R8 config id write ignored");
        // R10 per-core control
        access(1, 'h220, 2, 32'h3, "R10 control write");
        access(0, 'h220, 2, 0, "R10 control read own");
        access(0, 'h220, 1, 0, "R10 control read other");
        // R9 run-stall
        access(1, 'h200, 0, 32'h5, "R9 stall write");
        access(0, 'h200, 0, 0, "R9 stall read");
        access(0, 'h300, 0, 0, "R12 unmapped read high");
        access(0, 'h145, 0, 0, "R12 ipi set range reads zero");
        // R13 vectors change one edge after the capturing edge
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 10'h18C; req_core = 0; req_wdata = 32'h8000_0000;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check(core_irq[VW-1] === m_as[NL-1], "R13 not yet visible",
              64'(core_irq[VW-1]), 64'(m_as[NL-1]));
        model_write('h18C, 0, 32'h8000_0000);
        @(negedge clk);
        check(core_irq[VW-1] === 1'b1, "R13 visible next cycle", 64'(core_irq[VW-1]), 64'h1);

        for (int i = 0; i < 600; i++) begin
            int kind;
            kind = int'($urandom_range(0, 9));
            case (kind)
                0: access(1, int'($urandom_range(0, NL - 1)), 0, $urandom, "R2 rnd route");
                1: access(1, 'h140 + int'($urandom_range(0, 15)), 0, $urandom, "R4 rnd ipi set");
                2: access(1, 'h100 + int'($urandom_range(0, NC - 1)), 0, $urandom, "R5 rnd clear");
                3: access(1, 'h180 + 4 * int'($urandom_range(0, 3)), 0, $urandom, "R6 rnd mask");
                4: access(1, 'h190, 0, $urandom, "R7 rnd partition");
                5: access(1, 'h200, 0, $urandom, "R9 rnd stall");
                6: access(1, 'h220, int'($urandom_range(0, NC - 1)), $urandom, "R10 rnd ctrl");
                7: access(0, addrs[$urandom_range(0, 13)], int'($urandom_range(0, NC - 1)), 0,
                          "R12 rnd read");
                8: access(1, int'($urandom_range(32, 1023)), 0, $urandom, "R12 rnd any write");
                default: set_lines($urandom);
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule